// File: doc/BRIEF.md
# Successive Approximation ADC Controller

This block is the digital half of a successive-approximation analog-to-digital converter. A sample-and-hold, a DAC and an analog comparator sit outside it. When the sampled input is valid, the surrounding logic raises a start request. The controller then drives a trial code to the DAC and reads back one comparator bit, `trialHigh`. That bit is 1 when the trial code is above the held input and 0 when it is below. The controller settles one result bit per clock, from the most significant bit down.

Each conversion opens with the mid-scale code, only the MSB set. On each clock edge the bit under test is resolved from the comparator. If the trial was too high the bit is cleared, otherwise it is kept. The next lower bit is then set for the following trial. Once the last bit is resolved, the final code is copied to `resultCode` and `convDone` rises. `convDone` stays high, and the result stays frozen, for as long as `startReq` is held. When `startReq` drops, the controller clears `convDone` and waits for the next request.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves `trialCode` = 0, `resultCode` = 0 and `convDone` = 0, with the controller idle.
- R2: When the controller is idle and `startReq` is 1 at a rising edge, `trialCode` becomes 1000_0000 (0x80) after that edge.
- R3: On each decision edge of a conversion, the bit under test (starting at bit 7) is kept at 1 if `trialHigh` = 0 and cleared to 0 if `trialHigh` = 1. The next lower bit is set to 1, and all bits above the bit under test are unchanged.
- R4: A conversion makes exactly 8 decision edges after the mid-scale load edge. `convDone` rises on the 8th of them and stays 0 on the first 7.
- R5: `resultCode` changes only on the edge where `convDone` rises, and then it equals the fully resolved trial code. During a conversion it keeps the previous result.
- R6: While `convDone` = 1 and `startReq` = 1, `convDone`, `resultCode` and `trialCode` hold their values whatever `trialHigh` does.
- R7: When `convDone` = 1 and `startReq` = 0 at a rising edge, `convDone` is 0 after that edge and the controller is idle again, so a later start begins a new conversion.
- R8: The comparator sequence low, low, high, low, low, high, low, low (`trialHigh` = 0,0,1,0,0,1,0,0 in decision order) yields `resultCode` = 1101_1011 (0xDB).
- R9: While idle with `startReq` = 0, `trialHigh` is ignored: `trialCode` and `resultCode` keep their values.
- R10: With an ideal comparator (`trialHigh` = 1 exactly when `trialCode` exceeds the held input code), the result equals the input code for every 8-bit input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Conversion request, held high for the whole conversion and until the result has been taken |
| trialHigh | input | 1 | Comparator result: 1 means the trial code is above the input, 0 means below |
| trialCode | output | 8 | Trial code to the external DAC |
| resultCode | output | 8 | Final conversion result, valid while `convDone` is high |
| convDone | output | 1 | End-of-conversion flag |

## Verification
The assertions check on every cycle that a start from idle loads mid-scale and that a decision never disturbs the bits above the one under test. They also check that `convDone` rises exactly eight decision edges after the load, that the result only moves as `convDone` rises, and that the handshake holds and then releases the flag. Whether the resolved code is the right one for a given analog input can only be shown by the bench's scenarios. The bench sweeps all 256 input codes against an ideal comparator model, replays the forced comparator pattern that must produce 0xDB, and toggles the comparator while the controller is holding or idle.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_CONV  = 2'd1,
    ST_DONE  = 2'd2
  } sarState_t;

  // strobes from the sequencer to the code register
  typedef struct packed {
    logic load;    // load mid-scale trial
    logic decide;  // resolve the bit under test
    logic latch;   // copy resolved code to result, raise done
    logic clear;   // drop done flag
  } sarStrobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            startReq,
  output sarStrobe_t      strobes,
  output logic [IDXW-1:0] bitIdx,
  output sarState_t       stateQ
);

  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

  sarState_t stateNext;
  logic [IDXW-1:0] idxNext;

  always_comb begin
    strobes   = '0;
    stateNext = stateQ;
    idxNext   = bitIdx;
    unique case (stateQ)
      ST_READY: begin
        if (startReq) begin
          strobes.load = 1'b1;
          stateNext    = ST_CONV;
          idxNext      = TOP_IDX;
        end
      end
      ST_CONV: begin
        strobes.decide = 1'b1;
        if (bitIdx == '0) begin
          strobes.latch = 1'b1;
          stateNext     = ST_DONE;
        end else begin
          idxNext = bitIdx - 1'b1;
        end
      end
      ST_DONE: begin
        if (!startReq) begin
          strobes.clear = 1'b1;
          stateNext     = ST_READY;
        end
      end
      default: stateNext = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_READY;
      bitIdx <= TOP_IDX;
    end else begin
      stateQ <= stateNext;
      bitIdx <= idxNext;
    end
  end

  AST_ONE_STROBE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.load, strobes.decide, strobes.clear})); // R7

  AST_CONV_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_CONV && bitIdx != '0) |=> (stateQ == ST_CONV && bitIdx == $past(bitIdx) - 1'b1)); // R4

endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  sarStrobe_t       strobes,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             trialHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] resultCode,
  output logic             convDone
);

  logic [WIDTH-1:0] trialNext;
  logic [WIDTH-1:0] keepMask;   // bits at or below the bit under test

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic isTested;
    logic isNextLow;
    assign isTested  = (bitIdx == IDXW'(i));
    if (i < WIDTH - 1) begin : g_low
      assign isNextLow = (bitIdx == IDXW'(i + 1));
    end else begin : g_top
      assign isNextLow = 1'b0;
    end
    assign keepMask[i] = (IDXW'(i) <= bitIdx);

    always_comb begin
      trialNext[i] = trialCode[i];
      if (strobes.load) begin
        trialNext[i] = (i == WIDTH - 1);
      end else if (strobes.decide) begin
        if (isTested)       trialNext[i] = ~trialHigh;
        else if (isNextLow) trialNext[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trialCode  <= '0;
      resultCode <= '0;
      convDone   <= 1'b0;
    end else begin
      trialCode <= trialNext;
      if (strobes.latch) begin
        resultCode <= trialNext;
        convDone   <= 1'b1;
      end else if (strobes.clear) begin
        convDone <= 1'b0;
      end
    end
  end

  AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    strobes.decide |=> (((trialCode ^ $past(trialCode)) & ~$past(keepMask)) == '0)); // R3

  AST_TESTED_BIT_RULE: assert property (@(posedge clk) disable iff (rst)
    (strobes.decide && trialHigh) |=> ((trialCode & ~$past(trialCode) & ~($past(keepMask) >> 1)) == '0)); // R3

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             trialHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] resultCode,
  output logic             convDone
);

  localparam int IDXW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] MID_CODE = WIDTH'(1) << (WIDTH - 1);

  sarStrobe_t      strobes;
  logic [IDXW-1:0] bitIdx;
  sarState_t       stateQ;

  sar_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .strobes  (strobes),
    .bitIdx   (bitIdx),
    .stateQ   (stateQ)
  );

  sar_dpath #(.WIDTH(WIDTH)) i_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .bitIdx     (bitIdx),
    .trialHigh  (trialHigh),
    .trialCode  (trialCode),
    .resultCode (resultCode),
    .convDone   (convDone)
  );

  // decision-edge counter for the latency check
  logic [IDXW:0] stepCnt;
  always_ff @(posedge clk) begin
    if (rst)                                        stepCnt <= '0;
    else if (stateQ == ST_READY && startReq)        stepCnt <= '0;
    else if (stateQ == ST_CONV)                     stepCnt <= stepCnt + 1'b1;
  end

  AST_MIDSCALE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_READY && startReq) |=> (trialCode == MID_CODE)); // R2

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(convDone) |-> (stepCnt == (IDXW+1)'(WIDTH))); // R4

  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (resultCode != $past(resultCode)) |-> $rose(convDone)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (convDone && startReq) |=> (convDone && $stable(resultCode) && $stable(trialCode))); // R6

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (convDone && !startReq) |=> !convDone); // R7

  AST_IDLE_IGNORES_CMP: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_READY && !startReq) |=> ($stable(trialCode) && $stable(resultCode))); // R9

endmodule

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic forceCmp = 1'b0;
  logic forcedVal = 1'b0;
  logic [7:0] inCode = 8'd0;
  logic trialHigh;
  logic [7:0] trialCode, resultCode;
  logic convDone;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  // behavioural DAC + comparator
  assign trialHigh = forceCmp ? forcedVal : (trialCode > inCode);

  sar_adc_ctrl #(.WIDTH(8)) i_sar_adc_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startReq   (startReq),
    .trialHigh  (trialHigh),
    .trialCode  (trialCode),
    .resultCode (resultCode),
    .convDone   (convDone)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one conversion with the ideal comparator; checks each step
  task automatic convert_ideal(input logic [7:0] code, input logic [7:0] prevRes);
    logic [7:0] expTrial;
    inCode = code;
    forceCmp = 1'b0;
    startReq = 1'b1;
    @(negedge clk);
    check(trialCode == 8'h80, "R2 midscale", trialCode, 8'h80);
    check(convDone == 1'b0, "R4 done low at load", convDone, 0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      expTrial = code & (8'hFF << (8 - k));
      if (k < 8) expTrial = expTrial | (8'h01 << (7 - k));
      check(trialCode == expTrial, "R3 trial step", trialCode, expTrial);
      if (k < 8) begin
        check(convDone == 1'b0, "R4 done early", convDone, 0);
        check(resultCode == prevRes, "R5 result held in conv", resultCode, prevRes);
      end else begin
        check(convDone == 1'b1, "R4 done on 8th", convDone, 1);
        check(resultCode == code, "R10 result equals input", resultCode, code);
      end
    end
  endtask

  task automatic hold_and_release(input logic [7:0] code);
    forceCmp = 1'b1;
    for (int j = 0; j < 3; j++) begin
      forcedVal = j[0];
      @(negedge clk);
      check(convDone == 1'b1, "R6 done held", convDone, 1);
      check(resultCode == code, "R6 result held", resultCode, code);
      check(trialCode == code, "R6 trial held", trialCode, code);
    end
    startReq = 1'b0;
    @(negedge clk);
    check(convDone == 1'b0, "R7 done cleared", convDone, 0);
    for (int j = 0; j < 2; j++) begin
      forcedVal = ~forcedVal;
      @(negedge clk);
      check(trialCode == code, "R9 idle trial unchanged", trialCode, code);
      check(resultCode == code, "R9 idle result unchanged", resultCode, code);
    end
    forceCmp = 1'b0;
  endtask

  initial begin
    logic [7:0] pattern;
    logic [7:0] prevRes;
    startReq = 1'b1;  // reset must win over start
    repeat (3) @(negedge clk);
    check(trialCode == 8'h00, "R1 reset trial", trialCode, 0);
    check(resultCode == 8'h00, "R1 reset result", resultCode, 0);
    check(convDone == 1'b0, "R1 reset done", convDone, 0);
    startReq = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(convDone == 1'b0, "R1 idle after reset", convDone, 0);

    // R8 worked example with forced comparator sequence
    pattern = 8'b0010_0100;  // first decision is pattern[7]
    forceCmp = 1'b1;
    startReq = 1'b1;
    forcedVal = pattern[7];
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      forcedVal = pattern[7 - k];
      @(negedge clk);
    end
    check(convDone == 1'b1, "R8 done", convDone, 1);
    check(resultCode == 8'hDB, "R8 worked example", resultCode, 8'hDB);
    hold_and_release(8'hDB);

    // R10 exhaustive sweep, ideal comparator
    prevRes = 8'hDB;
    for (int v = 0; v < 256; v++) begin
      convert_ideal(8'(v), prevRes);
      hold_and_release(8'(v));
      prevRes = 8'(v);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule